// File: doc/BRIEF.md
# Cascadable Up/Down Binary Counter

This block is a synchronous binary counter of parameterised width (four bits by default) that counts up or down on the rising clock edge. It can also be preset from a data word through an active-low load strobe. The count advances only when two active-low enables are both asserted. The parallel enable is shared by every stage of a chain. The trickle enable is fed from the previous stage's carry.

An active-low terminal-count flag is decoded combinationally from the count, the direction and the trickle enable. To build a wider counter, one stage's flag drives the next stage's trickle enable. The parallel enables, load strobes, data slices and direction are shared across the stages. There is no reset input, so a known value is set by a load.

Each clock edge resolves to one of four named modes: MODE_LOAD, MODE_UP, MODE_DOWN and MODE_HOLD. The transitions are as follows:
- Load strobe low: any state goes to the data word (MODE_LOAD).
- Load high and both enables low: the state goes to count+1 with direction high (MODE_UP), or to count-1 with direction low (MODE_DOWN).
- Otherwise the state stays where it is (MODE_HOLD).

Top module: `updown_cascade_counter`

## Requirements
- R1: When `load_n` is 0 at a rising edge, `count` takes `din` on that edge, whatever `up_ndown`, `par_en_n` and `chain_en_n` are.
- R2: When `load_n` is 1, `par_en_n` is 0, `chain_en_n` is 0 and `up_ndown` is 1, `count` increments by one on the edge, wrapping from all ones to zero.
- R3: Under the same enables with `up_ndown` 0, `count` decrements by one on the edge, wrapping from zero to all ones.
- R4: When `load_n` is 1 and either `par_en_n` or `chain_en_n` is 1, `count` keeps its value on the edge.
- R5: `term_n` is 0 exactly when `chain_en_n` is 0 and the count is at its terminal value. The terminal value is all ones with `up_ndown` 1 and all zeros with `up_ndown` 0. Otherwise `term_n` is 1.
- R6: `term_n` does not depend on `par_en_n`.
- R7: `term_n` follows changes of `up_ndown` and `chain_en_n` within the same clock period, without waiting for an edge.
- R8: Two stages chained by connecting the low stage's `term_n` to the high stage's `chain_en_n` count as one 8-bit binary counter, up and down, including the carry and borrow between stages and the wrap of the full width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| up_ndown | input | 1 | Direction: 1 counts up, 0 counts down |
| par_en_n | input | 1 | Active-low parallel count enable |
| chain_en_n | input | 1 | Active-low trickle enable; also gates `term_n` |
| load_n | input | 1 | Active-low synchronous load strobe |
| din | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| term_n | output | 1 | Active-low terminal-count flag |

## Verification
Two functions can fall in the same cycle: a load strobe and a fully enabled count. They are provoked together by holding both enables low in the load cycle, with the direction set so that counting would give a different value. The check is that the loaded word, not the incremented count, appears after the edge.

The terminal flag can also be active in the cycle in which a load replaces the count. In that case the flag must reflect the old count before the edge and the new count after it.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    typedef enum logic [1:0] {
        MODE_HOLD = 2'd0,
        MODE_UP   = 2'd1,
        MODE_DOWN = 2'd2,
        MODE_LOAD = 2'd3
    } cnt_mode_e;

endpackage

// File: rtl/cnt_mode_dec.sv
module cnt_mode_dec
    import cnt_pkg::*;
(
    input  logic      up_ndown,
    input  logic      par_en_n,
    input  logic      chain_en_n,
    input  logic      load_n,
    output cnt_mode_e mode
);

    logic run;

    // both enables asserted and no load pending
    assign run = load_n & ~par_en_n & ~chain_en_n;

    always_comb begin
        if (!load_n) begin
            mode = MODE_LOAD;
        end else if (run) begin
            mode = up_ndown ? MODE_UP : MODE_DOWN;
        end else begin
            mode = MODE_HOLD;
        end
    end

endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  cnt_mode_e        mode,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    always_comb begin
        unique case (mode)
            MODE_LOAD: state_d = din;
            MODE_UP:   state_d = state_q + ONE;
            MODE_DOWN: state_d = state_q - ONE;
            MODE_HOLD: state_d = state_q;
            default:   state_d = state_q;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q;

endmodule

// File: rtl/cnt_term_dec.sv
module cnt_term_dec #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] count,
    input  logic             up_ndown,
    input  logic             chain_en_n,
    output logic             term_n
);

    logic [WIDTH-1:0] match;
    logic             at_end;

    // per-bit match against the terminal value of the selected direction
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign match[b] = up_ndown ? count[b] : ~count[b];
    end

    assign at_end = &match;

    always_comb begin
        term_n = ~(at_end & ~chain_en_n);
    end

endmodule

// File: rtl/updown_cascade_counter.sv
module updown_cascade_counter
    import cnt_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             up_ndown,
    input  logic             par_en_n,
    input  logic             chain_en_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] count,
    output logic             term_n
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    cnt_mode_e mode;

    cnt_mode_dec u_mode (
        .up_ndown   (up_ndown),
        .par_en_n   (par_en_n),
        .chain_en_n (chain_en_n),
        .load_n     (load_n),
        .mode       (mode)
    );

    cnt_state_reg #(.WIDTH(WIDTH)) u_state (
        .clk   (clk),
        .mode  (mode),
        .din   (din),
        .count (count)
    );

    cnt_term_dec #(.WIDTH(WIDTH)) u_term (
        .count      (count),
        .up_ndown   (up_ndown),
        .chain_en_n (chain_en_n),
        .term_n     (term_n)
    );

    // history-valid flag for the checks below; the block has no reset
    logic hist_ok = 1'b0;
    always_ff @(posedge clk) begin
        hist_ok <= 1'b1;
    end

    assert_load_wins_R1: assert property (@(posedge clk) disable iff (!hist_ok)
        !load_n |=> count == $past(din));

    assert_inc_wrap_R2: assert property (@(posedge clk) disable iff (!hist_ok)
        (load_n && !par_en_n && !chain_en_n && up_ndown) |=> count == $past(count) + ONE);

    assert_dec_wrap_R3: assert property (@(posedge clk) disable iff (!hist_ok)
        (load_n && !par_en_n && !chain_en_n && !up_ndown) |=> count == $past(count) - ONE);

    assert_hold_R4: assert property (@(posedge clk) disable iff (!hist_ok)
        (load_n && (par_en_n || chain_en_n)) |=> $stable(count));

    assert_term_gated_R5: assert property (@(posedge clk) disable iff (!hist_ok)
        chain_en_n |-> term_n);

endmodule

// File: tb/tb_updown_cascade_counter.sv
module tb_updown_cascade_counter;

    logic       clk = 1'b0;
    logic       up_ndown = 1'b1;
    logic       par_en_n = 1'b1;
    logic       chain_en_n = 1'b1;
    logic       load_n = 1'b0;
    logic [3:0] din = 4'h0;
    logic [3:0] count;
    logic       term_n;

    logic [7:0] c_din = 8'h00;
    logic [3:0] lo_q, hi_q;
    logic       lo_tc, hi_tc;
    logic       c_load_n = 1'b1;
    logic       c_par_n = 1'b1;
    logic       c_up = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    updown_cascade_counter #(.WIDTH(4)) dut (
        .clk(clk), .up_ndown(up_ndown), .par_en_n(par_en_n),
        .chain_en_n(chain_en_n), .load_n(load_n), .din(din),
        .count(count), .term_n(term_n)
    );

    updown_cascade_counter #(.WIDTH(4)) u_lo (
        .clk(clk), .up_ndown(c_up), .par_en_n(c_par_n), .chain_en_n(1'b0),
        .load_n(c_load_n), .din(c_din[3:0]), .count(lo_q), .term_n(lo_tc)
    );

    updown_cascade_counter #(.WIDTH(4)) u_hi (
        .clk(clk), .up_ndown(c_up), .par_en_n(c_par_n), .chain_en_n(lo_tc),
        .load_n(c_load_n), .din(c_din[7:4]), .count(hi_q), .term_n(hi_tc)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set(input logic ld, input logic pe, input logic ce, input logic up,
                       input logic [3:0] d);
        load_n = ld; par_en_n = pe; chain_en_n = ce; up_ndown = up; din = d;
    endtask

    task automatic t_load();
        set(1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
        tick();
        check("R1 initial load", {4'h0, count}, 8'h00);
        check("R5 idle flag", {7'h0, term_n}, 8'h01);
        set(1'b0, 1'b0, 1'b0, 1'b1, 4'hA);
        tick();
        check("R1 load over count", {4'h0, count}, 8'h0A);
        set(1'b0, 1'b0, 1'b0, 1'b0, 4'h5);
        tick();
        check("R1 load over down", {4'h0, count}, 8'h05);
    endtask

    task automatic t_up();
        set(1'b0, 1'b1, 1'b1, 1'b1, 4'hE);
        tick();
        set(1'b1, 1'b0, 1'b0, 1'b1, 4'h0);
        tick();
        check("R2 inc", {4'h0, count}, 8'h0F);
        check("R5 up terminal", {7'h0, term_n}, 8'h00);
        tick();
        check("R2 wrap", {4'h0, count}, 8'h00);
        check("R5 up not terminal", {7'h0, term_n}, 8'h01);
    endtask

    task automatic t_down();
        set(1'b0, 1'b1, 1'b1, 1'b0, 4'h1);
        tick();
        set(1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
        tick();
        check("R3 dec", {4'h0, count}, 8'h00);
        check("R5 down terminal", {7'h0, term_n}, 8'h00);
        tick();
        check("R3 wrap", {4'h0, count}, 8'h0F);
        check("R5 down not terminal", {7'h0, term_n}, 8'h01);
    endtask

    task automatic t_hold();
        set(1'b0, 1'b1, 1'b1, 1'b1, 4'hF);
        tick();
        set(1'b1, 1'b1, 1'b0, 1'b1, 4'h3);
        tick();
        check("R4 hold par", {4'h0, count}, 8'h0F);
        check("R6 flag ignores par enable", {7'h0, term_n}, 8'h00);
        set(1'b1, 1'b0, 1'b1, 1'b1, 4'h3);
        tick();
        check("R4 hold chain", {4'h0, count}, 8'h0F);
        check("R5 chain gates flag", {7'h0, term_n}, 8'h01);
    endtask

    task automatic t_comb();
        set(1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
        #1;
        check("R7 flag low", {7'h0, term_n}, 8'h00);
        up_ndown = 1'b0;
        #1;
        check("R7 dir change", {7'h0, term_n}, 8'h01);
        up_ndown = 1'b1;
        chain_en_n = 1'b1;
        #1;
        check("R7 chain change", {7'h0, term_n}, 8'h01);
        chain_en_n = 1'b0;
        #1;
        check("R7 chain back", {7'h0, term_n}, 8'h00);
    endtask

    task automatic t_chain();
        logic [7:0] model;
        c_din = 8'h0F; c_load_n = 1'b0; c_par_n = 1'b1; c_up = 1'b1;
        tick();
        c_load_n = 1'b1; c_par_n = 1'b0;
        tick();
        check("R8 carry", {hi_q, lo_q}, 8'h10);
        c_up = 1'b0;
        tick();
        check("R8 borrow", {hi_q, lo_q}, 8'h0F);
        c_din = 8'hF0; c_load_n = 1'b0; c_up = 1'b1;
        tick();
        c_load_n = 1'b1;
        model = 8'hF0;
        for (int i = 0; i < 20; i++) begin
            tick();
            model = model + 8'd1;
            check("R8 up run", {hi_q, lo_q}, model);
        end
        c_up = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            model = model - 8'd1;
            check("R8 down run", {hi_q, lo_q}, model);
        end
        c_par_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_load();
        t_up();
        t_down();
        t_hold();
        t_comb();
        t_chain();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule